// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block decides which of 32 general-purpose pins (four 8-bit ports) each enabled digital peripheral signal uses. A fixed priority list of nine peripherals, carrying fifteen signals in total, is placed in order. Each enabled peripheral takes the next free pins in ascending pin order. Pins can be kept out of the walk in two ways. An external-memory control can reserve its strobe pins. Any pin can also be placed in analog mode. Every pin that no signal claims stays a plain GPIO.

The mapping is computed combinationally from static configuration inputs and is registered once. Each pin therefore shows the result one clock after the configuration changes. Each pin has a 5-bit select code, an input-only flag and an output-driver enable. A global overflow flag reports that some enabled peripheral did not fit. All inputs and outputs are plain control levels, with no handshake.

Top module: `pin_xbar`

## Requirements
- R1: Peripherals are placed in a fixed priority order. The order is given as enable bit: signals, with each signal's select code in brackets: bit0 serial port A: TX(1), RX(2); bit1 SPI: SCK(3), MISO(4), MOSI(5), NSS(6); bit2 SMBus: SDA(7), SCL(8); bit3 serial port B: TX(9), RX(10); bit4 external interrupt 0 (11); bit5 external interrupt 1 (12); bit6 timer 0 count input (13); bit7 system clock output (14); bit8 conversion-start input (15). Within a peripheral, its signals take pins in the listed order.
- R2: Signals are placed on available pins in ascending order, starting at pin 0. Pin p's code sits at bits [5p+4:5p] of `pin_sel`.
- R3: A peripheral is placed only if all of its signals fit on the remaining available pins. The first enabled peripheral that does not fit is left out, together with every enabled peripheral below it in priority, and `overflow` is set to 1.
- R4: While `emif_lo_en` is 1, pins 7 (write strobe) and 6 (read strobe) are skipped, and pin 5 (address latch) is also skipped when `emif_mux` is 1. A skipped pin reads code 0.
- R5: A pin whose `analog_mode` bit is 1 is skipped by placement and reads code 0.
- R6: While `xbar_en` is 0, all codes, all driver enables and `overflow` are 0.
- R7: `pin_in_only` is 1 on a pin that carries an input-only signal (codes 2, 4, 6, 10, 11, 12, 13, 15). With `xbar_en` at 1, `pin_drv_en` is the inverse of `pin_in_only`.
- R8: A pin that no signal claims reads code 0 (GPIO). With `xbar_en` at 1, its driver enable is 1.
- R9: Outputs are 0 in reset. After reset, they reflect the configuration sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| per_en | input | 9 | Peripheral enables in priority order, bit 0 highest |
| emif_lo_en | input | 1 | External memory uses the low ports; skip strobe pins |
| emif_mux | input | 1 | Memory interface multiplexed; also skip latch pin |
| analog_mode | input | 32 | Per-pin analog mode, skipped by placement |
| pin_sel | output | 160 | Per-pin 5-bit select code, 0 = GPIO |
| pin_in_only | output | 32 | Pin carries an input-only function |
| pin_drv_en | output | 32 | Pin output driver enabled |
| overflow | output | 1 | An enabled peripheral could not be placed |

## Verification
The interesting coincidence is a multi-pin group being placed across pins that are skipped at the same time. One case is serial port B straddling the reserved memory strobe pins. Another is a group running out of pins just as analog-mode pins shrink the free pool. Both are provoked by directed configurations with hand-computed pin maps, and then by a broad sweep of random enable, skip and analog patterns. On every clock, a behavioural queue model in the bench judges all 32 codes, the flags and `overflow`.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NPER   = 9;
  localparam int NSIG   = 15;
  localparam int CODE_W = 5;

  // peripheral index that owns each signal, signals grouped by priority
  localparam int SIG_OWNER [NSIG] = '{0, 0, 1, 1, 1, 1, 2, 2, 3, 3, 4, 5, 6, 7, 8};

  // signals that are inputs only (no output driver)
  localparam logic [NSIG-1:0] SIG_INPUT = 15'b101_1110_0010_1010;

  function automatic int per_width(input int p);
    int n;
    n = 0;
    for (int s = 0; s < NSIG; s++)
      if (SIG_OWNER[s] == p) n++;
    return n;
  endfunction
endpackage

// File: rtl/pin_xbar_rank.sv
module pin_xbar_rank #(
  parameter int NPINS = 32,
  parameter int RW    = 6
) (
  input  logic [NPINS-1:0] avail,
  output logic [RW-1:0]    rank [NPINS],
  output logic [RW-1:0]    free_total
);
  // rank of a pin = number of available pins below it
  always_comb begin
    int acc;
    acc = 0;
    for (int p = 0; p < NPINS; p++) begin
      rank[p] = RW'(acc);
      if (avail[p]) acc++;
    end
    free_total = RW'(acc);
  end
endmodule

// File: rtl/pin_xbar_place.sv
module pin_xbar_place
  import pin_xbar_pkg::*;
#(
  parameter int RW = 6
) (
  input  logic [NPER-1:0] per_en,
  input  logic [RW-1:0]   free_total,
  output logic [RW-1:0]   sig_pos [NSIG],
  output logic [NSIG-1:0] placed,
  output logic            overflow
);
  always_comb begin
    int cum;
    int pend [NPER];
    cum = 0;
    for (int p = 0; p < NPER; p++) begin
      if (per_en[p]) cum += per_width(p);
      pend[p] = cum;
    end
    overflow = 1'b0;
    for (int p = 0; p < NPER; p++)
      if (per_en[p] && pend[p] > int'(free_total)) overflow = 1'b1;
    cum = 0;
    for (int s = 0; s < NSIG; s++) begin
      sig_pos[s] = RW'(cum);
      placed[s]  = per_en[SIG_OWNER[s]] && (pend[SIG_OWNER[s]] <= int'(free_total));
      if (per_en[SIG_OWNER[s]]) cum++;
    end
  end
endmodule

// File: rtl/pin_xbar_mux.sv
module pin_xbar_mux
  import pin_xbar_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int RW    = 6
) (
  input  logic [NPINS-1:0]  avail,
  input  logic [RW-1:0]     rank [NPINS],
  input  logic [RW-1:0]     sig_pos [NSIG],
  input  logic [NSIG-1:0]   placed,
  output logic [CODE_W-1:0] code [NPINS],
  output logic              in_only [NPINS]
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CODE_W-1:0] c;
    logic              io;
    always_comb begin
      c  = '0;
      io = 1'b0;
      for (int s = 0; s < NSIG; s++) begin
        if (avail[p] && placed[s] && sig_pos[s] == rank[p]) begin
          c  = CODE_W'(s + 1);
          io = SIG_INPUT[s];
        end
      end
    end
    assign code[p]    = c;
    assign in_only[p] = io;
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int WR_PIN  = 7,
  parameter int RD_PIN  = 6,
  parameter int ALE_PIN = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xbar_en,
  input  logic [NPER-1:0]          per_en,
  input  logic                     emif_lo_en,
  input  logic                     emif_mux,
  input  logic [NPINS-1:0]         analog_mode,
  output logic [NPINS*CODE_W-1:0]  pin_sel,
  output logic [NPINS-1:0]         pin_in_only,
  output logic [NPINS-1:0]         pin_drv_en,
  output logic                     overflow
);
  localparam int RW = $clog2(NPINS + 1);

  logic [NPINS-1:0]  skip_m, avail;
  logic [RW-1:0]     rank [NPINS];
  logic [RW-1:0]     free_total;
  logic [RW-1:0]     sig_pos [NSIG];
  logic [NSIG-1:0]   placed;
  logic              ovf_c;
  logic [CODE_W-1:0] code [NPINS];
  logic              io [NPINS];
  logic [NPINS*CODE_W-1:0] sel_n;
  logic [NPINS-1:0]  ino_n;

  always_comb begin
    skip_m = '0;
    if (emif_lo_en) begin
      skip_m[WR_PIN] = 1'b1;
      skip_m[RD_PIN] = 1'b1;
      if (emif_mux) skip_m[ALE_PIN] = 1'b1;
    end
  end
  assign avail = ~skip_m & ~analog_mode;

  pin_xbar_rank #(.NPINS(NPINS), .RW(RW)) u_rank (
    .avail(avail), .rank(rank), .free_total(free_total));

  pin_xbar_place #(.RW(RW)) u_place (
    .per_en(per_en), .free_total(free_total), .sig_pos(sig_pos),
    .placed(placed), .overflow(ovf_c));

  pin_xbar_mux #(.NPINS(NPINS), .RW(RW)) u_mux (
    .avail(avail), .rank(rank), .sig_pos(sig_pos), .placed(placed),
    .code(code), .in_only(io));

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      sel_n[p*CODE_W +: CODE_W] = code[p];
      ino_n[p] = io[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sel     <= '0;
      pin_in_only <= '0;
      pin_drv_en  <= '0;
      overflow    <= 1'b0;
    end else if (xbar_en) begin
      pin_sel     <= sel_n;
      pin_in_only <= ino_n;
      pin_drv_en  <= ~ino_n;
      overflow    <= ovf_c;
    end else begin
      pin_sel     <= '0;
      pin_in_only <= '0;
      pin_drv_en  <= '0;
      overflow    <= 1'b0;
    end
  end

  // assertion support: one cycle after reset, $past sees post-reset values
  logic             valid_q;
  logic [NPINS-1:0] sel_used;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end
  always_comb
    for (int p = 0; p < NPINS; p++) sel_used[p] = |pin_sel[p*CODE_W +: CODE_W];

  AST_IN_ONLY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_in_only & pin_drv_en) == '0); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !$past(xbar_en) |-> (pin_drv_en == '0 && pin_sel == '0 && !overflow)); // R6
  AST_STROBE_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && $past(emif_lo_en) |->
      (pin_sel[WR_PIN*CODE_W +: CODE_W] == '0 && pin_sel[RD_PIN*CODE_W +: CODE_W] == '0)); // R4
  AST_ANALOG_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (sel_used & $past(analog_mode)) == '0); // R5
endmodule

// File: tb/pin_xbar_test.sv
module pin_xbar_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xbar_en = 1'b0;
  logic [8:0] per_en = '0;
  logic emif_lo_en = 1'b0, emif_mux = 1'b0;
  logic [31:0] analog_mode = '0;
  logic [159:0] pin_sel;
  logic [31:0] pin_in_only, pin_drv_en;
  logic overflow;

  int vec = 0;
  int mis = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pin_xbar uut (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .per_en(per_en),
    .emif_lo_en(emif_lo_en), .emif_mux(emif_mux), .analog_mode(analog_mode),
    .pin_sel(pin_sel), .pin_in_only(pin_in_only), .pin_drv_en(pin_drv_en),
    .overflow(overflow));

  // behavioural reference: queue of signals walked over free pins
  function automatic void model(input logic en, input logic [8:0] pe,
      input logic el, input logic em, input logic [31:0] an,
      output logic [31:0][4:0] code, output logic [31:0] ino,
      output logic [31:0] drv, output logic ovf);
    int w [9] = '{2, 4, 2, 2, 1, 1, 1, 1, 1};
    int f [9] = '{0, 2, 6, 8, 10, 11, 12, 13, 14};
    logic [14:0] inset = 15'b101_1110_0010_1010;
    int q[$];
    int nfree, used;
    bit stop, avl;
    code = '0; ino = '0; drv = '0; ovf = 1'b0;
    if (!en) return;
    nfree = 0;
    for (int p = 0; p < 32; p++)
      if (!an[p] && !(el && (p == 7 || p == 6 || (em && p == 5)))) nfree++;
    used = 0; stop = 0;
    for (int k = 0; k < 9; k++) begin
      if (pe[k]) begin
        if (!stop && used + w[k] <= nfree) begin
          for (int j = 0; j < w[k]; j++) q.push_back(f[k] + j);
          used += w[k];
        end else begin
          stop = 1; ovf = 1'b1;
        end
      end
    end
    for (int p = 0; p < 32; p++) begin
      avl = !an[p] && !(el && (p == 7 || p == 6 || (em && p == 5)));
      if (avl && q.size() > 0) begin
        int s;
        s = q.pop_front();
        code[p] = 5'(s + 1);
        ino[p] = inset[s];
      end
    end
    drv = ~ino;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      mis++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sel(input int p);
    return int'(pin_sel[p*5 +: 5]);
  endfunction

  // per-clock comparison against the model, sampled a quarter period after the edge
  always @(posedge clk) begin
    logic [31:0][4:0] ec;
    logic [31:0] ei, ed;
    logic eo;
    if (!rst_n) begin
      ec = '0; ei = '0; ed = '0; eo = 1'b0;
    end else begin
      model(xbar_en, per_en, emif_lo_en, emif_mux, analog_mode, ec, ei, ed, eo);
    end
    #(CLK_P/4);
    if (!done) begin
      vec++;
      for (int p = 0; p < 32; p++) begin
        if (sel(p) != int'(ec[p])) begin
          mis++;
          $display("FAIL R2 pin %0d code: actual %0d expected %0d", p, sel(p), ec[p]);
        end
      end
      if (pin_in_only != ei) begin
        mis++;
        $display("FAIL R7 in_only: actual %h expected %h", pin_in_only, ei);
      end
      if (pin_drv_en != ed) begin
        mis++;
        $display("FAIL R7 drv_en: actual %h expected %h", pin_drv_en, ed);
      end
      if (overflow != eo) begin
        mis++;
        $display("FAIL R3 overflow: actual %0d expected %0d", overflow, eo);
      end
    end
  end

  task automatic cfg(input logic en, input logic [8:0] pe, input logic el,
                     input logic em, input logic [31:0] an);
    @(negedge clk);
    xbar_en = en; per_en = pe; emif_lo_en = el; emif_mux = em; analog_mode = an;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    mis++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    // reset with a live configuration applied
    xbar_en = 1'b1; per_en = 9'h1FF;
    repeat (3) @(negedge clk);
    chk("R9", "reset pin_sel or", int'(|pin_sel), 0);
    chk("R9", "reset drv_en", int'(pin_drv_en), 0);
    chk("R9", "reset overflow", int'(overflow), 0);
    rst_n = 1'b1;

    // R9: one-cycle latency after a change
    @(negedge clk);
    xbar_en = 1'b1; per_en = 9'h001; emif_lo_en = 0; emif_mux = 0; analog_mode = '0;
    @(posedge clk); #1;
    chk("R9", "pin0 one cycle later", sel(0), 1);
    per_en = 9'h000;
    #(CLK_P/4);
    chk("R9", "pin0 before edge", sel(0), 1);

    // R6: disabled crossbar
    cfg(1'b0, 9'h1FF, 1'b0, 1'b0, '0);
    chk("R6", "pin0 code", sel(0), 0);
    chk("R6", "drv_en", int'(pin_drv_en), 0);

    // R1 R4: priority example with multiplexed memory interface
    cfg(1'b1, 9'b000111101, 1'b1, 1'b1, '0);
    chk("R1", "pin0 U-A TX", sel(0), 1);
    chk("R1", "pin1 U-A RX", sel(1), 2);
    chk("R1", "pin2 SDA", sel(2), 7);
    chk("R1", "pin3 SCL", sel(3), 8);
    chk("R1", "pin4 U-B TX", sel(4), 9);
    chk("R4", "pin5 latch skipped", sel(5), 0);
    chk("R4", "pin7 wr skipped", sel(7), 0);
    chk("R4", "pin8 U-B RX", sel(8), 10);
    chk("R1", "pin10 INT1", sel(10), 12);
    chk("R7", "pin1 in_only", int'(pin_in_only[1]), 1);
    chk("R7", "pin1 drv", int'(pin_drv_en[1]), 0);
    chk("R8", "pin11 gpio", sel(11), 0);

    // R4: non-multiplexed, only strobes skipped
    cfg(1'b1, 9'b000111101, 1'b1, 1'b0, '0);
    chk("R4", "pin5 U-B RX", sel(5), 10);
    chk("R4", "pin8 INT0", sel(8), 11);

    // R2 R8: everything enabled, no skips
    cfg(1'b1, 9'h1FF, 1'b0, 1'b0, '0);
    for (int p = 0; p < 15; p++) chk("R2", "ascending fill", sel(p), p + 1);
    chk("R8", "pin15 gpio", sel(15), 0);
    chk("R8", "pin31 drv", int'(pin_drv_en[31]), 1);
    chk("R3", "no overflow", int'(overflow), 0);

    // R5: analog pins skipped
    cfg(1'b1, 9'h001, 1'b0, 1'b0, 32'h0000_0003);
    chk("R5", "pin0 analog", sel(0), 0);
    chk("R5", "pin2 U-A TX", sel(2), 1);

    // R3: SPI cannot fit on three free pins; INT0 also dropped
    cfg(1'b1, 9'b000010011, 1'b0, 1'b0, 32'hFFFF_FFF8);
    chk("R3", "pin1 U-A RX", sel(1), 2);
    chk("R3", "pin2 left free", sel(2), 0);
    chk("R3", "overflow set", int'(overflow), 1);
    cfg(1'b1, 9'b000010001, 1'b0, 1'b0, 32'hFFFF_FFF8);
    chk("R3", "pin2 INT0 fits", sel(2), 11);
    chk("R3", "overflow clear", int'(overflow), 0);

    // sweep: model compared on every clock
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      xbar_en = ($urandom % 8) != 0;
      per_en = 9'($urandom);
      emif_lo_en = $urandom % 2;
      emif_mux = $urandom % 2;
      case ($urandom % 3)
        0: analog_mode = '0;
        1: analog_mode = $urandom & $urandom;
        default: analog_mode = ~(32'($urandom % 16) << ($urandom % 28));
      endcase
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule